// File: doc/BRIEF.md
# Excess-3 Serial Decimal Digit Adder

This block adds two decimal digits given in Excess-3 code, where each code equals the digit value plus three, together with a carry bit. It returns an Excess-3 sum digit and a carry-out. The correction happens in the code itself, with no detour through plain binary. The raw 5-bit sum of the two codes and the carry is corrected by minus three when it stays below sixteen, and by plus three when it reaches sixteen. Bit 4 of the corrected word is the carry-out.

Multi-digit numbers are added one digit per accepted beat, least significant digit first. A small two-state controller holds the running carry between digits. A start pulse opens a new number, and a last marker closes it. Results appear on a registered output stage one cycle after each accepted digit pair. An operand that is not a legal Excess-3 code raises an error flag and forces a defined result.

The controller has two states:
- `ST_IDLE`: no number is in progress.
- `ST_CHAIN`: a number is in progress, and the stored carry feeds the next digit.

Its transitions are:
- `T_OPEN`: `ST_IDLE` goes to `ST_CHAIN` on start, or on an accepted digit without last.
- `T_STEP`: `ST_CHAIN` stays in `ST_CHAIN` on an accepted digit without last, or on an idle cycle.
- `T_CLOSE`: any state goes to `ST_IDLE` on an accepted digit marked last.

Top module: `xs3_serial_adder`

## Requirements
- R1: After reset, out_valid, sum_code, carry_out and code_err are all 0, and the controller is in ST_IDLE.
- R2: For valid operands with digit values A = a_code-3 and B = b_code-3, and carry c, the result sum_code equals ((A+B+c) mod 10) + 3.
- R3: For valid operands, carry_out is 1 exactly when A+B+c is at least 10.
- R4: out_valid is 1 in exactly the cycle after each cycle with in_valid = 1, and is 0 otherwise.
- R5: When either operand code is outside 3..12, code_err is 1, sum_code is 0 and carry_out is 0. For valid operands, code_err is 0.
- R6: A digit accepted in the same cycle as start uses cin_seed as its carry-in.
- R7: Within a number, each digit after the first uses the carry_out of the previous accepted digit as its carry-in.
- R8: A digit accepted with last = 1 ends the number. The next digit accepted without start uses carry-in 0.
- R9: start with in_valid = 0 clears the stored carry and produces no output. The next digit accepted without start uses carry-in 0.
- R10: A digit with a code error stores carry 0, so the following digit in the number uses carry-in 0.
- R11: cin_seed has no effect on any digit accepted without start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a new number and clears the stored carry |
| in_valid | input | 1 | Digit pair on a_code/b_code is accepted this cycle |
| last | input | 1 | Accepted digit is the most significant of its number |
| cin_seed | input | 1 | Carry-in for the digit accepted together with start |
| a_code | input | 4 | First operand digit, Excess-3 |
| b_code | input | 4 | Second operand digit, Excess-3 |
| out_valid | output | 1 | Result registers hold a new result |
| sum_code | output | 4 | Sum digit, Excess-3 (0 on error) |
| carry_out | output | 1 | Decimal carry from this digit |
| code_err | output | 1 | An operand was not a legal Excess-3 code |

## Verification
The bench builds the block with its 4-bit digit width. At that width, every pair of decimal digits and both carry values can be swept, giving all 200 legal cases, along with all sixteen code values of one operand, including the six illegal ones. Expected values come from integer decimal arithmetic on the decoded digits. Short scripted numbers then exercise carry rippling across several digits. They also cover the start, last and error rules that decide which carry each digit sees.

// File: rtl/xs3_pkg.sv
package xs3_pkg;
    localparam int DIGIT_W  = 4;
    localparam int BIAS     = 3;
    localparam int CODE_MIN = BIAS;
    localparam int CODE_MAX = BIAS + 9;
    localparam int RAW_W    = DIGIT_W + 1;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CHAIN = 1'b1
    } chain_state_e;

    typedef struct packed {
        logic               err;
        logic               cout;
        logic [DIGIT_W-1:0] sum;
    } digit_res_t;
endpackage

// File: rtl/xs3_digit_core.sv
module xs3_digit_core
    import xs3_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output digit_res_t         res
);
    localparam logic [RAW_W-1:0] BIAS_V = RAW_W'(BIAS);
    localparam logic [DIGIT_W-1:0] LO   = DIGIT_W'(CODE_MIN);
    localparam logic [DIGIT_W-1:0] HI   = DIGIT_W'(CODE_MAX);

    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] fixed;
    logic             a_ok;
    logic             b_ok;

    always_comb begin
        raw   = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        // overflow past the code width selects the upward correction
        fixed = raw[RAW_W-1] ? raw + BIAS_V : raw - BIAS_V;
        a_ok  = (a >= LO) && (a <= HI);
        b_ok  = (b >= LO) && (b <= HI);
        if (a_ok && b_ok) begin
            res.err  = 1'b0;
            res.cout = fixed[RAW_W-1];
            res.sum  = fixed[DIGIT_W-1:0];
        end else begin
            res.err  = 1'b1;
            res.cout = 1'b0;
            res.sum  = '0;
        end
    end
endmodule

// File: rtl/xs3_chain_ctrl.sv
module xs3_chain_ctrl
    import xs3_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic last,
    input  logic cin_seed,
    input  logic digit_cout,
    input  logic digit_err,
    output logic carry_use
);
    chain_state_e state_q, state_d;
    logic         carry_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && last)      state_d = ST_IDLE;   // T_CLOSE
                else if (start || in_valid) state_d = ST_CHAIN; // T_OPEN
            end
            ST_CHAIN: begin
                if (in_valid && last)      state_d = ST_IDLE;   // T_CLOSE
                else                       state_d = ST_CHAIN;  // T_STEP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        carry_q <= 1'b0;
        else if (in_valid) carry_q <= digit_err ? 1'b0 : digit_cout;
        else if (start)    carry_q <= 1'b0;
    end

    always_comb begin
        if (start)                  carry_use = cin_seed;
        else if (state_q == ST_CHAIN) carry_use = carry_q;
        else                        carry_use = 1'b0;
    end

    AST_CLOSE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last) |=> (state_q == ST_IDLE)); // R8
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_valid) |=> (state_q == ST_CHAIN && carry_q == 1'b0)); // R9
    AST_ERR_DROPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && digit_err) |=> (carry_q == 1'b0)); // R10
    AST_SEED_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && state_q == ST_IDLE) |-> (carry_use == 1'b0)); // R11
endmodule

// File: rtl/xs3_serial_adder.sv
module xs3_serial_adder
    import xs3_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               in_valid,
    input  logic               last,
    input  logic               cin_seed,
    input  logic [DIGIT_W-1:0] a_code,
    input  logic [DIGIT_W-1:0] b_code,
    output logic               out_valid,
    output logic [DIGIT_W-1:0] sum_code,
    output logic               carry_out,
    output logic               code_err
);
    localparam logic [DIGIT_W-1:0] LO = DIGIT_W'(CODE_MIN);
    localparam logic [DIGIT_W-1:0] HI = DIGIT_W'(CODE_MAX);

    logic       carry_use;
    digit_res_t res;

    xs3_chain_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .last       (last),
        .cin_seed   (cin_seed),
        .digit_cout (res.cout),
        .digit_err  (res.err),
        .carry_use  (carry_use)
    );

    xs3_digit_core u_core (
        .a   (a_code),
        .b   (b_code),
        .cin (carry_use),
        .res (res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_code  <= '0;
            carry_out <= 1'b0;
            code_err  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_code  <= res.sum;
                carry_out <= res.cout;
                code_err  <= res.err;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R4
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R4
    AST_ERR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && code_err) |-> (sum_code == '0 && !carry_out)); // R5
    AST_SUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !code_err) |-> (sum_code >= LO && sum_code <= HI)); // R2
endmodule

// File: tb/tb_xs3_serial_adder.sv
module tb_xs3_serial_adder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, in_valid = 1'b0, last = 1'b0, cin_seed = 1'b0;
    logic [3:0] a_code = '0, b_code = '0;
    logic       out_valid, carry_out, code_err;
    logic [3:0] sum_code;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xs3_serial_adder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .last(last), .cin_seed(cin_seed), .a_code(a_code), .b_code(b_code),
        .out_valid(out_valid), .sum_code(sum_code), .carry_out(carry_out),
        .code_err(code_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one beat: drive on falling edge, sample just after the rising edge
    task automatic beat(input bit st, input bit iv, input bit lst, input bit seed,
                        input int a, input int b);
        @(negedge clk);
        start = st; in_valid = iv; last = lst; cin_seed = seed;
        a_code = 4'(a); b_code = 4'(b);
        @(posedge clk);
        #1;
        @(negedge clk);
        start = 0; in_valid = 0; last = 0; cin_seed = 0;
    endtask

    // check a result for digit values da, db and carry c
    task automatic expect_dig(input string tag, input int da, input int db, input int c);
        int t;
        t = da + db + c;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " sum"}, int'(sum_code), (t % 10) + 3);
        chk({tag, " cout"}, int'(carry_out), (t >= 10) ? 1 : 0);
        chk({tag, " err"}, int'(code_err), 0);
    endtask

    task automatic digit(input bit st, input bit lst, input bit seed,
                         input int da, input int db, input int c, input string tag);
        @(negedge clk);
        start = st; in_valid = 1; last = lst; cin_seed = seed;
        a_code = 4'(da + 3); b_code = 4'(db + 3);
        @(posedge clk);
        #1;
        expect_dig(tag, da, db, c);
        @(negedge clk);
        start = 0; in_valid = 0; last = 0; cin_seed = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 sum_code", int'(sum_code), 0);
        chk("R1 carry_out", int'(carry_out), 0);
        chk("R1 code_err", int'(code_err), 0);
        @(negedge clk); rst_n = 1;

        // R2 R3 R6: exhaustive single digits, carry seeded with start
        for (int da = 0; da < 10; da++)
            for (int db = 0; db < 10; db++)
                for (int c = 0; c < 2; c++)
                    digit(1, 1, c[0], da, db, c, "R2 R3 R6 sweep");

        // R4: no output on an idle cycle
        beat(0, 0, 0, 0, 3, 3);
        chk("R4 idle no valid", int'(out_valid), 0);

        // R5: all codes of one operand
        for (int a = 0; a < 16; a++) begin
            beat(1, 1, 1, 0, a, 3);
            if (a < 3 || a > 12) begin
                chk("R5 err", int'(code_err), 1);
                chk("R5 sum zero", int'(sum_code), 0);
                chk("R5 cout zero", int'(carry_out), 0);
            end else begin
                chk("R5 no err", int'(code_err), 0);
                chk("R5 sum", int'(sum_code), a);
            end
        end
        beat(1, 1, 1, 0, 7, 15);
        chk("R5 err b", int'(code_err), 1);

        // R7: 9999 + 0001 ripples a carry through every digit
        digit(1, 0, 0, 9, 1, 0, "R7 d0");
        digit(0, 0, 0, 9, 0, 1, "R7 d1");
        digit(0, 0, 0, 9, 0, 1, "R7 d2");
        digit(0, 1, 0, 9, 0, 1, "R7 d3");

        // R8: after last, a digit without start uses carry 0
        digit(1, 1, 0, 9, 9, 0, "R8 close");
        digit(0, 1, 0, 0, 0, 0, "R8 fresh");

        // R9: start alone clears the stored carry
        digit(1, 0, 1, 9, 9, 1, "R9 setup");
        beat(1, 0, 0, 0, 0, 0);
        chk("R9 no valid", int'(out_valid), 0);
        digit(0, 1, 0, 0, 0, 0, "R9 cleared");

        // R10: an erroneous digit stores carry 0
        digit(1, 0, 0, 9, 9, 0, "R10 setup");
        beat(0, 1, 0, 0, 0, 5);
        chk("R10 err", int'(code_err), 1);
        digit(0, 1, 0, 0, 0, 0, "R10 after err");

        // R11: cin_seed ignored without start, in chain and in idle
        digit(1, 0, 0, 2, 2, 0, "R11 setup");
        digit(0, 1, 1, 2, 2, 0, "R11 chain");
        digit(0, 1, 1, 4, 5, 0, "R11 idle");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule